// File: doc/BRIEF.md
# Dual-Port Reservation-Based Atomic Word Unit

This block lets two processors perform read-modify-write updates on words of a shared memory without any lock. Each processor port reaches three registers through a 2-bit select. A sequence starts with a write of the word address to the address register, which also arms that port's reservation. The processor then reads the word through the data register, computes the new value itself, and writes it back through the same data register. This covers exchange, add, subtract, clear-bits and set-bits. A read of the data register then acts as a flush, and a final read of the status register reports the outcome.

A status of zero means the sequence was atomic. A nonzero status means another port stored to the same word, or this port's store was refused, so software must restart from the address write. A compare-and-swap whose comparison fails may leave out the store and still finish with the flush and status reads.

The block holds one reservation per port, a single-port synchronous word memory, and a fixed-priority arbiter. The arbiter stalls port 1 through its ready output whenever both ports want the memory in the same cycle.

Top module: `atomic_ops_unit`

## Requirements
- R1: After reset both reservations are invalid, both rvalid outputs are low, port 0 is ready, and a status read returns 1.
- R2: A read is accepted on a clock edge where req and ready are both high. rvalid is high in the following cycle, with the response on rdata. Select 2'b01 (data) returns the memory word at the port's reserved address.
- R3: A data write (select 2'b01) by a port holding a valid reservation stores wdata into the reserved word, and a data read in the next cycle returns it.
- R4: A status read (select 2'b10) returns 0 if the port's reservation is valid and 1 otherwise, and it invalidates that reservation, so a second status read returns 1.
- R5: A stored data write by one port invalidates the other port's reservation when both name the same word. Reservations on other words, and the writer's own reservation, are kept.
- R6: A data write from a port whose reservation is invalid leaves memory unchanged, and the port's status read returns 1.
- R7: When both ports request the data register in the same cycle, port 0 is served and port 1 sees ready low. Port 1 is served in a later cycle, after the effects of port 0's access.
- R8: Address (select 2'b00), status and unused-select accesses never stall; port 0 is always ready.
- R9: A sequence of address write, data read, flush read and status read with no data write reports status 0.
- R10: Reads of the address register and of unused select 2'b11 return 0. Writes to the status register or with select 2'b11 change nothing.
- R11: An address write accepted in the same cycle as the other port's store to that word leaves the new reservation valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p0_req | input | 1 | Port 0 access request |
| p0_we | input | 1 | Port 0 write (1) or read (0) |
| p0_sel | input | 2 | Port 0 register select: 00 address, 01 data, 10 status, 11 unused |
| p0_wdata | input | DW | Port 0 write data; low AW bits are the word address on address writes |
| p0_ready | output | 1 | Port 0 access accepted this cycle |
| p0_rvalid | output | 1 | Port 0 read response valid |
| p0_rdata | output | DW | Port 0 read response |
| p1_req | input | 1 | Port 1 access request |
| p1_we | input | 1 | Port 1 write (1) or read (0) |
| p1_sel | input | 2 | Port 1 register select, same coding as port 0 |
| p1_wdata | input | DW | Port 1 write data |
| p1_ready | output | 1 | Port 1 access accepted this cycle |
| p1_rvalid | output | 1 | Port 1 read response valid |
| p1_rdata | output | DW | Port 1 read response |

## Verification
The hardest case to reach is two ports colliding on one word inside the same cycle. Examples are two simultaneous stores to a word both ports reserved, where the stalled store of port 1 must be refused because port 0's store has just taken its reservation, and an address write that lands on the very edge where the other port stores to that word. Directed dual-port tasks drive both ports in the same cycle for these cases. Random single-port operations then aim at only four word addresses, so that reservation losses and refused stores happen often.

// File: rtl/aou_pkg.sv
package aou_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'b00,
    SEL_DATA = 2'b01,
    SEL_STAT = 2'b10,
    SEL_NONE = 2'b11
  } sel_e;

  typedef enum logic [1:0] {
    RSP_ZERO = 2'b00,
    RSP_MEM  = 2'b01,
    RSP_STAT = 2'b10
  } rsp_e;
endpackage

// File: rtl/aou_arb.sv
module aou_arb #(
  parameter int NP = 2
) (
  input  logic [NP-1:0] want,
  output logic [NP-1:0] gnt,
  output logic [NP-1:0] ready
);
  logic taken;

  always_comb begin
    taken = 1'b0;
    gnt   = '0;
    for (int p = 0; p < NP; p++) begin
      gnt[p] = want[p] && !taken;
      taken  = taken || want[p];
    end
    ready = ~want | gnt;
  end
endmodule

// File: rtl/aou_resv.sv
module aou_resv #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [AW-1:0] set_addr,
  input  logic          clr_en,
  input  logic          snoop_wr,
  input  logic [AW-1:0] snoop_addr,
  output logic          vld,
  output logic [AW-1:0] addr
);
  logic          vld_q, vld_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          kill;

  assign kill = snoop_wr && vld_q && (snoop_addr == addr_q);

  always_comb begin
    vld_d  = vld_q;
    addr_d = addr_q;
    if (clr_en || kill) vld_d = 1'b0;
    // a new sequence overrides any clear arriving on the same edge
    if (set_en) begin
      vld_d  = 1'b1;
      addr_d = set_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (set_en) addr_q <= addr_d;
    end
  end

  assign vld  = vld_q;
  assign addr = addr_q;
endmodule

// File: rtl/aou_mem.sv
module aou_mem #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) store[addr] <= wdata;
      else    rdata_q     <= store[addr];
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/aou_resp.sv
module aou_resp
  import aou_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_acc,
  input  logic [1:0]    sel,
  input  logic          stat_fail,
  input  logic [DW-1:0] mem_rdata,
  output logic          rvalid,
  output logic [DW-1:0] rdata
);
  logic rvalid_q;
  rsp_e kind_q, kind_d;
  logic stat_q;

  always_comb begin
    case (sel)
      SEL_DATA: kind_d = RSP_MEM;
      SEL_STAT: kind_d = RSP_STAT;
      default:  kind_d = RSP_ZERO;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      kind_q   <= RSP_ZERO;
      stat_q   <= 1'b0;
    end else begin
      rvalid_q <= rd_acc;
      if (rd_acc) begin
        kind_q <= kind_d;
        stat_q <= stat_fail;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rvalid_q) begin
      case (kind_q)
        RSP_MEM:  rdata = mem_rdata;
        RSP_STAT: rdata = {{(DW-1){1'b0}}, stat_q};
        default:  rdata = '0;
      endcase
    end
  end

  assign rvalid = rvalid_q;
endmodule

// File: rtl/atomic_ops_unit.sv
module atomic_ops_unit
  import aou_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          p0_req,
  input  logic          p0_we,
  input  logic [1:0]    p0_sel,
  input  logic [DW-1:0] p0_wdata,
  output logic          p0_ready,
  output logic          p0_rvalid,
  output logic [DW-1:0] p0_rdata,
  input  logic          p1_req,
  input  logic          p1_we,
  input  logic [1:0]    p1_sel,
  input  logic [DW-1:0] p1_wdata,
  output logic          p1_ready,
  output logic          p1_rvalid,
  output logic [DW-1:0] p1_rdata
);
  localparam int NP = 2;

  logic [NP-1:0] req_v, we_v, ready_v, rvalid_v;
  logic [1:0]    sel_v   [NP];
  logic [DW-1:0] wdata_v [NP];
  logic [DW-1:0] rdata_v [NP];

  assign req_v    = {p1_req, p0_req};
  assign we_v     = {p1_we, p0_we};
  assign sel_v[0] = p0_sel;
  assign sel_v[1] = p1_sel;
  assign wdata_v[0] = p0_wdata;
  assign wdata_v[1] = p1_wdata;
  assign p0_ready  = ready_v[0];
  assign p1_ready  = ready_v[1];
  assign p0_rvalid = rvalid_v[0];
  assign p1_rvalid = rvalid_v[1];
  assign p0_rdata  = rdata_v[0];
  assign p1_rdata  = rdata_v[1];

  logic [NP-1:0] want_mem, acc, addr_wr, stat_rd, rd_acc, snoop_wr;
  logic [NP-1:0] rv_vld;
  logic [AW-1:0] rv_addr [NP];
  logic [AW-1:0] rv_addr0, rv_addr1;
  logic [NP-1:0] mem_gnt;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  aou_arb #(.NP(NP)) u_arb (
    .want  (want_mem),
    .gnt   (mem_gnt),
    .ready (ready_v)
  );

  generate
    for (genvar gp = 0; gp < NP; gp++) begin : g_port
      assign want_mem[gp] = req_v[gp] && (sel_v[gp] == SEL_DATA);
      assign acc[gp]      = req_v[gp] && ready_v[gp];
      assign addr_wr[gp]  = acc[gp] && we_v[gp] && (sel_v[gp] == SEL_ADDR);
      assign stat_rd[gp]  = acc[gp] && !we_v[gp] && (sel_v[gp] == SEL_STAT);
      assign rd_acc[gp]   = acc[gp] && !we_v[gp];
      assign snoop_wr[gp] = mem_we && !mem_gnt[gp];

      aou_resv #(.AW(AW)) u_resv (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (addr_wr[gp]),
        .set_addr   (wdata_v[gp][AW-1:0]),
        .clr_en     (stat_rd[gp]),
        .snoop_wr   (snoop_wr[gp]),
        .snoop_addr (mem_addr),
        .vld        (rv_vld[gp]),
        .addr       (rv_addr[gp])
      );

      aou_resp #(.DW(DW)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_acc    (rd_acc[gp]),
        .sel       (sel_v[gp]),
        .stat_fail (!rv_vld[gp]),
        .mem_rdata (mem_rdata),
        .rvalid    (rvalid_v[gp]),
        .rdata     (rdata_v[gp])
      );
    end
  endgenerate

  assign rv_addr0 = rv_addr[0];
  assign rv_addr1 = rv_addr[1];

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_we    = 1'b0;
    for (int p = 0; p < NP; p++) begin
      if (mem_gnt[p]) begin
        mem_addr  = rv_addr[p];
        mem_wdata = wdata_v[p];
        mem_we    = we_v[p] && rv_vld[p];
      end
    end
  end

  assign mem_en = |mem_gnt;

  aou_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk   (clk),
    .en    (mem_en),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );
endmodule

// File: rtl/aou_check.sv
module aou_check #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          p0_req,
  input logic          p0_we,
  input logic [1:0]    p0_sel,
  input logic          p0_ready,
  input logic          p0_rvalid,
  input logic          p1_req,
  input logic          p1_we,
  input logic [1:0]    p1_sel,
  input logic          p1_ready,
  input logic          p1_rvalid,
  input logic [1:0]    resv_vld,
  input logic [AW-1:0] resv_a0,
  input logic [AW-1:0] resv_a1,
  input logic          mem_we,
  input logic [1:0]    mem_gnt
);
  assert_p1_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_req && p0_sel == 2'b01 && p1_req && p1_sel == 2'b01) |-> !p1_ready);

  assert_gnt_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_gnt));

  assert_no_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_req && p1_sel != 2'b01) |-> p1_ready);

  assert_rsp0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_req && p0_ready && !p0_we) |=> p0_rvalid);

  assert_rsp1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_req && p1_ready && !p1_we) |=> p1_rvalid);

  assert_rsp_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    p1_rvalid |-> $past(p1_req && p1_ready && !p1_we));

  assert_stat_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_req && p0_ready && !p0_we && p0_sel == 2'b10) |=> !resv_vld[0]);

  assert_store_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> |(mem_gnt & resv_vld));

  assert_kill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_gnt[1] && resv_vld[0] && resv_a0 == resv_a1 &&
     !(p0_req && p0_we && p0_sel == 2'b00)) |=> !resv_vld[0]);
endmodule

bind atomic_ops_unit aou_check #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .p0_req    (p0_req),
  .p0_we     (p0_we),
  .p0_sel    (p0_sel),
  .p0_ready  (p0_ready),
  .p0_rvalid (p0_rvalid),
  .p1_req    (p1_req),
  .p1_we     (p1_we),
  .p1_sel    (p1_sel),
  .p1_ready  (p1_ready),
  .p1_rvalid (p1_rvalid),
  .resv_vld  (rv_vld),
  .resv_a0   (rv_addr0),
  .resv_a1   (rv_addr1),
  .mem_we    (mem_we),
  .mem_gnt   (mem_gnt)
);

// File: tb/atomic_ops_unit_tb.sv
module atomic_ops_unit_tb_top;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] S_ADDR = 2'b00, S_DATA = 2'b01, S_STAT = 2'b10, S_NONE = 2'b11;

  logic clk, rst_n;
  logic p0_req, p0_we, p0_ready, p0_rvalid;
  logic p1_req, p1_we, p1_ready, p1_rvalid;
  logic [1:0] p0_sel, p1_sel;
  logic [DW-1:0] p0_wdata, p0_rdata, p1_wdata, p1_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [DW-1:0] mdl_mem [DEPTH];
  bit            mdl_rv  [2];
  logic [AW-1:0] mdl_ra  [2];

  atomic_ops_unit #(.DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .p0_req(p0_req), .p0_we(p0_we), .p0_sel(p0_sel), .p0_wdata(p0_wdata),
    .p0_ready(p0_ready), .p0_rvalid(p0_rvalid), .p0_rdata(p0_rdata),
    .p1_req(p1_req), .p1_we(p1_we), .p1_sel(p1_sel), .p1_wdata(p1_wdata),
    .p1_ready(p1_ready), .p1_rvalid(p1_rvalid), .p1_rdata(p1_rdata)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: act=running exp=done");
    report();
  end

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference model of one accepted access; returns the expected read response
  function automatic logic [DW-1:0] mstep(input int p, input bit w, input logic [1:0] s, input logic [DW-1:0] d);
    int q = 1 - p;
    logic [DW-1:0] e = '0;
    case (s)
      S_ADDR: if (w) begin mdl_rv[p] = 1; mdl_ra[p] = d[AW-1:0]; end
      S_DATA: begin
        if (w) begin
          if (mdl_rv[p]) begin
            mdl_mem[mdl_ra[p]] = d;
            if (mdl_rv[q] && mdl_ra[q] == mdl_ra[p]) mdl_rv[q] = 0;
          end
        end
        e = mdl_mem[mdl_ra[p]];
      end
      S_STAT: if (!w) begin e = mdl_rv[p] ? '0 : 1; mdl_rv[p] = 0; end
      default: e = '0;
    endcase
    return e;
  endfunction

  task automatic drive(input int p, input bit r, input bit w, input logic [1:0] s, input logic [DW-1:0] d);
    if (p == 0) begin p0_req = r; p0_we = w; p0_sel = s; p0_wdata = d; end
    else        begin p1_req = r; p1_we = w; p1_sel = s; p1_wdata = d; end
  endtask

  function automatic bit rdy(input int p);
    return (p == 0) ? p0_ready : p1_ready;
  endfunction
  function automatic bit rvl(input int p);
    return (p == 0) ? p0_rvalid : p1_rvalid;
  endfunction
  function automatic logic [DW-1:0] rdt(input int p);
    return (p == 0) ? p0_rdata : p1_rdata;
  endfunction

  // single access from a negedge; returns at the negedge after acceptance
  task automatic do_op(input int p, input bit w, input logic [1:0] s, input logic [DW-1:0] d, input string tag);
    logic [DW-1:0] e;
    drive(p, 1, w, s, d);
    forever begin
      #1;
      if (rdy(p)) break;
      @(posedge clk); @(negedge clk);
    end
    e = mstep(p, w, s, d);
    @(posedge clk); @(negedge clk);
    drive(p, 0, 0, S_NONE, '0);
    if (!w) begin
      chk(rvl(p) == 1'b1, {tag, " rvalid"}, {31'd0, rvl(p)}, 1);
      chk(rdt(p) == e, tag, rdt(p), e);
    end
  endtask

  // both ports start in the same cycle; port 0 is modelled first
  task automatic dual(input bit w0, input logic [1:0] s0, input logic [DW-1:0] d0,
                      input bit w1, input logic [1:0] s1, input logic [DW-1:0] d1,
                      input bit stall, input string tag);
    logic [DW-1:0] e0, e1;
    drive(0, 1, w0, s0, d0);
    drive(1, 1, w1, s1, d1);
    #1;
    chk(p0_ready == 1'b1, {tag, " p0 ready"}, {31'd0, p0_ready}, 1);
    chk(p1_ready == !stall, {tag, " p1 ready"}, {31'd0, p1_ready}, {31'd0, !stall});
    e0 = mstep(0, w0, s0, d0);
    if (!stall) e1 = mstep(1, w1, s1, d1);
    @(posedge clk); @(negedge clk);
    drive(0, 0, 0, S_NONE, '0);
    if (!w0) chk(p0_rvalid && p0_rdata == e0, {tag, " p0 data"}, p0_rdata, e0);
    if (stall) begin
      #1;
      chk(p1_ready == 1'b1, {tag, " p1 later ready"}, {31'd0, p1_ready}, 1);
      e1 = mstep(1, w1, s1, d1);
      @(posedge clk); @(negedge clk);
    end
    drive(1, 0, 0, S_NONE, '0);
    if (!w1) chk(p1_rvalid && p1_rdata == e1, {tag, " p1 data"}, p1_rdata, e1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    drive(0, 0, 0, S_NONE, '0);
    drive(1, 0, 0, S_NONE, '0);
    mdl_rv[0] = 0; mdl_rv[1] = 0; mdl_ra[0] = '0; mdl_ra[1] = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(p0_rvalid == 0 && p1_rvalid == 0, "R1 rvalid low", {30'd0, p1_rvalid, p0_rvalid}, 0);
    chk(p0_ready == 1, "R1 p0 ready", {31'd0, p0_ready}, 1);
    do_op(0, 0, S_STAT, '0, "R1 status after reset");
    do_op(1, 0, S_STAT, '0, "R1 p1 status after reset");

    // fill memory with known content
    for (int a = 0; a < DEPTH; a++) begin
      do_op(0, 1, S_ADDR, a, "R3 init addr");
      do_op(0, 1, S_DATA, (a * 32'h01010101) ^ 32'h5A5A_0000, "R3 init data");
      do_op(0, 0, S_STAT, '0, "R4 init status");
    end

    // R2/R3/R4 basic add sequence
    do_op(0, 1, S_ADDR, 5, "R2 addr");
    do_op(0, 0, S_DATA, '0, "R2 read word");
    do_op(0, 1, S_DATA, mdl_mem[5] + 32'd17, "R3 write");
    do_op(0, 0, S_DATA, '0, "R3 flush read");
    do_op(0, 0, S_STAT, '0, "R4 status ok");
    do_op(0, 0, S_STAT, '0, "R4 second status fails");

    // R5 conflicting store
    do_op(0, 1, S_ADDR, 7, "R5 p0 addr");
    do_op(1, 1, S_ADDR, 7, "R5 p1 addr");
    do_op(1, 1, S_DATA, 32'hCAFE_0007, "R5 p1 store");
    do_op(1, 0, S_STAT, '0, "R5 writer keeps reservation");
    do_op(0, 0, S_STAT, '0, "R5 victim fails");
    do_op(0, 1, S_ADDR, 8, "R5 p0 addr 8");
    do_op(1, 1, S_ADDR, 9, "R5 p1 addr 9");
    do_op(1, 1, S_DATA, 32'h0000_0999, "R5 other word store");
    do_op(0, 0, S_STAT, '0, "R5 other word unaffected");
    do_op(1, 0, S_STAT, '0, "R5 p1 status");

    // R6 store without reservation
    do_op(0, 1, S_DATA, 32'hDEAD_BEEF, "R6 suppressed store");
    do_op(0, 0, S_STAT, '0, "R6 status fails");
    do_op(0, 1, S_ADDR, 8, "R6 re-address");
    do_op(0, 0, S_DATA, '0, "R6 memory unchanged");
    do_op(0, 0, S_STAT, '0, "R6 status clear");

    // R9 compare-and-swap with mismatch
    do_op(1, 1, S_ADDR, 3, "R9 addr");
    do_op(1, 0, S_DATA, '0, "R9 read");
    do_op(1, 0, S_DATA, '0, "R9 flush");
    do_op(1, 0, S_STAT, '0, "R9 status ok");

    // R10 unused select and ignored writes
    do_op(0, 1, S_ADDR, 11, "R10 addr");
    do_op(0, 0, S_ADDR, '0, "R10 address read zero");
    do_op(0, 0, S_NONE, '0, "R10 unused read zero");
    do_op(0, 1, S_NONE, 32'hFFFF_FFFF, "R10 unused write");
    do_op(0, 1, S_STAT, 32'hFFFF_FFFF, "R10 status write");
    do_op(0, 0, S_DATA, '0, "R10 word unchanged");
    do_op(0, 0, S_STAT, '0, "R10 reservation kept");

    // R7 simultaneous stores on a word reserved by both ports
    do_op(0, 1, S_ADDR, 10, "R7 p0 addr");
    do_op(1, 1, S_ADDR, 10, "R7 p1 addr");
    dual(1, S_DATA, 32'h1111_0A0A, 1, S_DATA, 32'h2222_0A0A, 1, "R7 dual store");
    do_op(0, 0, S_DATA, '0, "R7 port0 value kept");
    do_op(0, 0, S_STAT, '0, "R7 p0 status");
    do_op(1, 0, S_STAT, '0, "R7 p1 refused");
    do_op(0, 1, S_ADDR, 20, "R7 p0 addr 20");
    do_op(1, 1, S_ADDR, 21, "R7 p1 addr 21");
    dual(0, S_DATA, '0, 0, S_DATA, '0, 1, "R7 dual read");

    // R8 and R11 non-memory access beside a store
    do_op(1, 1, S_ADDR, 12, "R11 p1 addr");
    do_op(0, 1, S_ADDR, 12, "R11 p0 addr");
    dual(1, S_DATA, 32'h0C0C_1212, 1, S_ADDR, 12, 0, "R8 R11 store with addr write");
    do_op(1, 0, S_STAT, '0, "R11 reservation survives");
    dual(0, S_DATA, '0, 0, S_STAT, '0, 0, "R8 data with status");

    // random phase, four hot words
    for (int i = 0; i < 600; i++) begin
      int p = $urandom % 2;
      int k = $urandom % 11;
      logic [DW-1:0] cur = mdl_mem[mdl_ra[p]];
      logic [DW-1:0] v = $urandom;
      case (k)
        0, 1: do_op(p, 1, S_ADDR, $urandom % 4, "R2 rand addr");
        2, 3, 4: do_op(p, 0, S_DATA, '0, "R2 rand read");
        5: do_op(p, 1, S_DATA, v, "R3 rand xchg");
        6: do_op(p, 1, S_DATA, cur + (v & 32'hFF), "R3 rand add");
        7: do_op(p, 1, S_DATA, cur - (v & 32'hFF), "R3 rand sub");
        8: do_op(p, 1, S_DATA, ($urandom % 2) ? (cur & ~v) : (cur | v), "R5 rand mask");
        9: do_op(p, 0, S_STAT, '0, "R4 rand status");
        default: do_op(p, $urandom % 2, S_NONE, v, "R10 rand unused");
      endcase
    end

    report();
  end
endmodule